// File: doc/BRIEF.md
# Seven-to-one serial lane deserializer

This block turns a group of serial video lanes back into parallel pixel words. Every lane carries seven bits per pixel period. A sampling clock running at seven times the pixel rate samples each lane, and it also samples the forwarded clock lane. The forwarded clock lane repeats a fixed seven-sample shape, and the block uses that shape to find where each word starts. After it has found the word boundary, the block collects seven samples from every data lane. It publishes the combined word on a wide parallel output together with a pixel-rate strobe.

The `LANES` parameter picks the variant. Four lanes give a 28-bit word: 24 colour bits plus horizontal sync, vertical sync, data enable and one spare control line. Three lanes give a 21-bit word: 18 colour bits plus the three sync and enable lines. An active-low power-down input forces the outputs low. A lock timer keeps the outputs quiet for a set number of sampling cycles after reset and after each power-down. If the forwarded clock pattern goes missing, the block keeps the last published word and searches for the boundary again.

Top module: `pix_lane_deser`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pix_data`, `pix_strobe` and `word_aligned` are 0 after that edge.
- R2: The clock lane carries 1,1,0,0,0,1,1 at sample positions 0 to 6 of each word. While searching, a sample of 0 that follows a sample of 1 is taken as position 2, and `word_aligned` is 1 after that same edge.
- R3: Within a word, the sample that lane k carries at position j appears on `pix_data` bit 7k+j. This holds for both the 3-lane (21-bit) and the 4-lane (28-bit) variants.
- R4: A word whose clock-lane samples match the pattern is published on `pix_data` at the edge that samples its position 6.
- R5: `pix_strobe` rises at the edge that publishes a word. It falls at the edge that samples position 2 of the next word. `pix_data` changes only at edges where the strobe rises, so the data is stable across every falling edge of the strobe.
- R6: While `pdn_n` is low at an edge, `pix_data` and `pix_strobe` are 0 and `word_aligned` is 0 after that edge.
- R7: After reset and after `pdn_n` returns high, no word is published until `LOCK_CYCLES` edges have passed with `pdn_n` high. Alignment search still runs during this interval.
- R8: One word with a wrong clock-lane pattern is not published and leaves `word_aligned` at 1. Two wrong words in a row clear `word_aligned`, and `pix_data` keeps the last published word. A clock lane stuck high or stuck low counts as a wrong pattern.
- R9: After alignment is lost, the first correct word is found again from its falling transition and is published at its position 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, seven times the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_n | input | 1 | Active-low power-down |
| clk_lane | input | 1 | Sampled forwarded clock lane |
| data_lanes | input | LANES | One sampled bit per data lane per cycle |
| pix_data | output | 7*LANES | Recovered parallel word |
| pix_strobe | output | 1 | Pixel-rate strobe; its falling edge qualifies `pix_data` |
| word_aligned | output | 1 | Word boundary found and being tracked |

## Verification
Every result has a fixed due time. The output word, the strobe rise and any alignment drop are due one edge after the position-6 sample of the word that causes them. The strobe fall is due one edge after the position-2 sample of the next word. The alignment flag is due one edge after the first position-2 sample. The bench drives one sample at each falling clock edge and reads the outputs at the falling edge that follows each relevant rising edge, so every check lands exactly one register stage after its cause. Lock-interval checks are placed only on words whose position 6 falls clearly before or clearly after `LOCK_CYCLES`, so no check depends on which of two adjacent edges ends the interval.

// File: rtl/deser7_pkg.sv
// Shared constants and types for the seven-to-one lane deserializer.
// Assumes one sample per lane per sampling-clock cycle, seven per word.
package deser7_pkg;
    localparam int WORD_BITS = 7;
    // Clock-lane sample at position j sits in bit j (position 0 in bit 0).
    localparam logic [WORD_BITS-1:0] CLK_PATTERN = 7'b1100011;
    // Position of the first low sample after the high run.
    localparam int FALL_POS = 2;
    // Position whose sampling edge drops the output strobe.
    localparam int STROBE_FALL_POS = 2;
    // Consecutive bad words that end alignment.
    localparam int MISS_LIMIT = 2;

    typedef enum logic {ALN_SEARCH, ALN_TRACK} aln_state_e;
endpackage

// File: rtl/deser_shift7.sv
// Per-lane sample history. Presents the newest WORD_BITS samples,
// including the one arriving this cycle, oldest in bit 0.
// Assumes the caller reads the history only at word boundaries.
module deser_shift7 #(
    parameter int BITS = deser7_pkg::WORD_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    output logic [BITS-1:0] hist_next
);
    logic [BITS-2:0] older_q;

    assign hist_next = {din, older_q};

    // Shift the newest sample in at the top and drop the oldest.
    always_ff @(posedge clk) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= hist_next[BITS-1:1];
    end
endmodule

// File: rtl/deser_lock_timer.sv
// Start-up quiet timer. Counts sampling edges with power-down released
// and reports when LOCK_CYCLES of them have passed. Assumes LOCK_CYCLES >= 1.
module deser_lock_timer #(
    parameter int LOCK_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn_n,
    output logic done
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q == LIMIT);

    // Restart on reset or power-down, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !pdn_n) cnt_q <= '0;
        else if (!done)       cnt_q <= cnt_q + 1'b1;
    end

    AST_LOCK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> !done);                                              // R7
endmodule

// File: rtl/deser_frame_align.sv
// Word framing from the clock lane. While searching it waits for a
// falling transition (taken as position 2), then tracks the position
// modulo seven and checks each completed clock-lane word against the
// pattern. MISS_LIMIT bad words in a row send it back to search.
module deser_frame_align
    import deser7_pkg::*;
#(
    parameter int PHASE_W = $clog2(WORD_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pdn_n,
    input  logic [WORD_BITS-1:0] clk_hist,
    output logic                 aligned,
    output logic [PHASE_W-1:0]   phase,
    output logic                 word_end,
    output logic                 pat_ok
);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [PHASE_W-1:0] LAST_POS  = PHASE_W'(WORD_BITS - 1);
    localparam logic [PHASE_W-1:0] AFTER_FALL = PHASE_W'(FALL_POS + 1);

    aln_state_e        state_q;
    logic [PHASE_W-1:0] phase_q;
    logic [MISS_W-1:0]  miss_q;
    logic               fall;

    assign fall     = clk_hist[WORD_BITS-2] & ~clk_hist[WORD_BITS-1];
    assign aligned  = (state_q == ALN_TRACK);
    assign phase    = phase_q;
    assign word_end = aligned && (phase_q == LAST_POS);
    assign pat_ok   = (clk_hist == CLK_PATTERN);

    // Search for the boundary, then track position and count bad words.
    always_ff @(posedge clk) begin
        if (!rst_n || !pdn_n) begin
            state_q <= ALN_SEARCH;
            phase_q <= '0;
            miss_q  <= '0;
        end else if (state_q == ALN_SEARCH) begin
            if (fall) begin
                state_q <= ALN_TRACK;
                phase_q <= AFTER_FALL;
            end
        end else begin
            phase_q <= word_end ? '0 : phase_q + 1'b1;
            if (word_end) begin
                if (pat_ok) begin
                    miss_q <= '0;
                end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
                    state_q <= ALN_SEARCH;
                    phase_q <= '0;
                    miss_q  <= '0;
                end else begin
                    miss_q <= miss_q + 1'b1;
                end
            end
        end
    end

    AST_SINGLE_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && !pat_ok && miss_q == '0 && pdn_n) |=> aligned);    // R8
endmodule

// File: rtl/pix_lane_deser.sv
// Seven-to-one serial lane deserializer, top level. Gathers seven samples
// per data lane into a parallel word, framed by the clock lane. Publishes
// only matched words after the lock interval, drives a pixel-rate strobe,
// clears outputs in power-down and holds the last word when framing is lost.
// Assumes LANES is 3 or 4 and every input is already in the clk domain.
module pix_lane_deser
    import deser7_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int LOCK_CYCLES = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pdn_n,
    input  logic                       clk_lane,
    input  logic [LANES-1:0]           data_lanes,
    output logic [LANES*WORD_BITS-1:0] pix_data,
    output logic                       pix_strobe,
    output logic                       word_aligned
);
    localparam int OUT_W   = LANES * WORD_BITS;
    localparam int PHASE_W = $clog2(WORD_BITS);
    localparam logic [PHASE_W-1:0] DROP_POS = PHASE_W'(STROBE_FALL_POS);

    logic [WORD_BITS-1:0] clk_hist;
    logic [OUT_W-1:0]     word_next;
    logic                 aligned;
    logic [PHASE_W-1:0]   phase;
    logic                 word_end;
    logic                 pat_ok;
    logic                 lock_done;
    logic                 publish;

    // One history per data lane; lane k fills bits 7k..7k+6.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        deser_shift7 #(.BITS(WORD_BITS)) u_hist (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (data_lanes[k]),
            .hist_next(word_next[k*WORD_BITS +: WORD_BITS])
        );
    end

    deser_shift7 #(.BITS(WORD_BITS)) u_clk_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (clk_lane),
        .hist_next(clk_hist)
    );

    deser_frame_align #(.PHASE_W(PHASE_W)) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .pdn_n   (pdn_n),
        .clk_hist(clk_hist),
        .aligned (aligned),
        .phase   (phase),
        .word_end(word_end),
        .pat_ok  (pat_ok)
    );

    deser_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk  (clk),
        .rst_n(rst_n),
        .pdn_n(pdn_n),
        .done (lock_done)
    );

    assign publish      = word_end && pat_ok && lock_done;
    assign word_aligned = aligned;

    // Output word and strobe: clear in power-down, load on publish, drop strobe mid-word.
    always_ff @(posedge clk) begin
        if (!rst_n || !pdn_n) begin
            pix_data   <= '0;
            pix_strobe <= 1'b0;
        end else if (publish) begin
            pix_data   <= word_next;
            pix_strobe <= 1'b1;
        end else if (aligned && phase == DROP_POS) begin
            pix_strobe <= 1'b0;
        end
    end

    AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> (pix_data == '0 && !pix_strobe));                    // R6
    AST_DATA_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pdn_n) && pix_data != $past(pix_data)) |-> pix_strobe);  // R5
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n || !pdn_n)
        $rose(pix_strobe) |=> pix_strobe ##1 pix_strobe ##1 !pix_strobe); // R5
    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_done |=> !$rose(pix_strobe));                             // R7
    AST_HOLD_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(word_aligned) && $past(pdn_n)) |-> $stable(pix_data));   // R8
endmodule

// File: tb/sim_pix_lane_deser.sv
// Bench: 4-lane instance u0 and 3-lane instance u1 share the stimulus.
// Inputs are driven at falling edges and results read at falling edges.
module sim_pix_lane_deser;
    localparam logic [6:0] GOOD  = 7'b1100011;
    localparam logic [6:0] HIGHS = 7'h7F;
    localparam logic [6:0] LOWS  = 7'h00;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, pdn_n, clk_lane;
    logic [3:0] lanes;
    logic [27:0] d4;
    logic [20:0] d3;
    logic s4, s3, a4, a3;
    int n_chk = 0;
    int n_bad = 0;

    pix_lane_deser #(.LANES(4), .LOCK_CYCLES(20)) u0 (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .clk_lane(clk_lane),
        .data_lanes(lanes), .pix_data(d4), .pix_strobe(s4), .word_aligned(a4));
    pix_lane_deser #(.LANES(3), .LOCK_CYCLES(20)) u1 (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .clk_lane(clk_lane),
        .data_lanes(lanes[2:0]), .pix_data(d3), .pix_strobe(s3), .word_aligned(a3));

    task automatic chk(input string tag, input logic [27:0] act, input logic [27:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_part(input logic [27:0] w, input logic [6:0] pat,
                             input int j0, input int j1);
        for (int j = j0; j <= j1; j++) begin
            clk_lane = pat[j];
            for (int k = 0; k < 4; k++) lanes[k] = w[7*k + j];
            @(negedge clk);
        end
    endtask

    task automatic send_word(input logic [27:0] w, input logic [6:0] pat);
        send_part(w, pat, 0, 6);
    endtask

    function automatic logic [27:0] mix(input int i);
        return 28'((i * 32'h00B4F1D3) ^ 32'h00A5C3E7 ^ (i << 13));
    endfunction

    task automatic finish_up;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        logic [27:0] last;
        rst_n = 1'b0; pdn_n = 1'b1; clk_lane = 1'b0; lanes = '0;
        repeat (4) @(negedge clk);
        chk("R1 data", d4, 28'h0);
        chk("R1 strobe/aligned", {26'h0, s4, a4}, 28'h0);
        chk("R1 3-lane", {7'h0, d3}, 28'h0);
        rst_n = 1'b1;

        // Framing found at the first position-2 sample.
        send_part(mix(100), GOOD, 0, 1);
        chk("R2 not yet aligned", {27'h0, a4}, 28'h0);
        send_part(mix(100), GOOD, 2, 2);
        chk("R2 aligned", {26'h0, a3, a4}, 28'h3);
        send_part(mix(100), GOOD, 3, 6);
        chk("R7 quiet word0", d4, 28'h0);
        send_word(mix(101), GOOD);
        chk("R7 quiet word1", {s4, d4[26:0]} , 28'h0);
        send_word(mix(102), GOOD);
        send_word(mix(103), GOOD);
        chk("R4 first publish", d4, mix(103));
        chk("R5 strobe up", {27'h0, s4}, 28'h1);

        // Strobe timing across the next word.
        last = mix(103);
        send_part(mix(104), GOOD, 0, 1);
        chk("R5 strobe held", {27'h0, s4}, 28'h1);
        chk("R5 data held", d4, last);
        send_part(mix(104), GOOD, 2, 2);
        chk("R5 strobe fell", {27'h0, s4}, 28'h0);
        chk("R5 data at fall", d4, last);
        send_part(mix(104), GOOD, 3, 6);
        chk("R5 next word", d4, mix(104));

        // Walking one across every output bit, both widths.
        for (int b = 0; b < 28; b++) begin
            send_word(28'h1 << b, GOOD);
            chk("R3 4-lane map", d4, 28'h1 << b);
            chk("R3 3-lane map", {7'h0, d3}, {7'h0, 21'((28'h1 << b) & 28'h1FFFFF)});
        end

        // Arithmetic sweep of words.
        for (int i = 0; i < 32; i++) begin
            send_word(mix(i), GOOD);
            chk("R4 sweep", d4, mix(i));
            last = mix(i);
        end

        // One bad word is tolerated; two end alignment and hold the data.
        send_word(28'hFFFFFFF, HIGHS);
        chk("R8 single miss data", d4, last);
        chk("R8 single miss aligned", {27'h0, a4}, 28'h1);
        send_word(mix(200), GOOD);
        chk("R8 publish after miss", d4, mix(200));
        send_word(mix(201), HIGHS);
        chk("R8 first of two", {27'h0, a4}, 28'h1);
        send_word(mix(202), HIGHS);
        chk("R8 lost", {27'h0, a4}, 28'h0);
        chk("R8 held", d4, mix(200));
        send_word(mix(203), GOOD);
        chk("R9 realigned", {27'h0, a4}, 28'h1);
        chk("R9 republished", d4, mix(203));
        chk("R9 3-lane", {7'h0, d3}, {7'h0, mix(203) & 28'h1FFFFF});
        send_word(mix(204), LOWS);
        send_word(mix(205), LOWS);
        chk("R8 stuck low lost", {27'h0, a4}, 28'h0);
        chk("R8 stuck low held", d4, mix(203));
        send_word(mix(206), GOOD);
        chk("R9 after stuck low", d4, mix(206));

        // Power-down mid-word, then lock interval again.
        send_part(mix(300), GOOD, 0, 3);
        pdn_n = 1'b0;
        send_part(mix(300), GOOD, 4, 4);
        chk("R6 data low", d4, 28'h0);
        chk("R6 strobe/aligned low", {26'h0, s4, a4}, 28'h0);
        send_part(mix(300), GOOD, 5, 6);
        send_word(mix(301), GOOD);
        chk("R6 stays low", {s4, d4[26:0]}, 28'h0);
        chk("R6 3-lane low", {7'h0, d3}, 28'h0);
        pdn_n = 1'b1;
        send_word(mix(302), GOOD);
        chk("R7 aligns during lock", {27'h0, a4}, 28'h1);
        send_word(mix(303), GOOD);
        chk("R7 quiet after release", d4, 28'h0);
        send_word(mix(304), GOOD);
        send_word(mix(305), GOOD);
        chk("R7 publish after lock", d4, mix(305));
        finish_up();
    end
endmodule